// File: doc/BRIEF.md
# Outbound Address Translator

This block rewrites local bus addresses into link-side addresses by means of a small set of programmable translation windows (two by default). Each window holds an enable bit, a transaction kind, a 64-bit base, a 32-bit inclusive upper bound for the low address word, and a 64-bit target. A local request that falls inside an enabled window leaves the block one clock later. It carries the rewritten address, the kind of that window and a hit flag. A request that matches no window passes through unchanged with the hit flag low.

Software never addresses a window directly. It first writes a selector register that names one window and a direction. All later accesses to the shared group of window registers then reach that window only. The fields may be written in any order, and a window takes part in matching only while its enable bit is set. For configuration kinds, the low target word is a routing word that holds the bus number in bits 31:24, the device number in bits 23:19 and the function number in bits 18:16. Because the address rewrite adds the in-window offset, that routing word reaches the link unaltered, with the register offset placed in the low bits.

Top module: `atu_outbound`

## Requirements
- R1: After synchronous reset, every window is disabled, every register reads zero, and `out_valid` and `out_hit` are low.
- R2: The selector register at offset 0x900 stores bit 31 (direction: 1 = inbound, 0 = outbound) and bit 0 (window index). It reads back those two bits and returns zero in all other bits.
- R3: With an outbound window selected, the window registers read back the fields of that window only, and writes change that window only. The registers are: kind in bits 4:0 at 0x904, base low at 0x90C, base high at 0x910, bound at 0x914, target low at 0x918 and target high at 0x91C. The fields may be written in any order.
- R4: While the selector has bit 31 set, writes to the window registers change no window, and reads of the window registers return zero.
- R5: Bit 31 of the register at 0x908 is the window enable. All other bits of that register, bit 30 included, are discarded on write and read as zero.
- R6: A request hits a window only when that window is enabled, the high address word equals the base high word, and the low address word lies between base low and the bound, both ends included.
- R7: On a hit, `out_addr` equals the 64-bit target plus (request address minus 64-bit base), taken modulo 2^64, and `out_kind` equals the window's kind (memory 0, I/O 2, configuration type 0 is 4, configuration type 1 is 5).
- R8: When several windows hit, the window with the lowest index supplies the address and the kind.
- R9: When no window hits, `out_hit` is 0, `out_kind` is 0 and `out_addr` equals the request address.
- R10: The results of a request appear exactly one clock after it is presented, with `out_valid` a one-cycle copy of `req_valid`. A register write made on the same clock edge as a request does not affect that request.
- R11: For a configuration window whose target low word holds bus, device and function in bits 31:24, 23:19 and 18:16, and whose size is below 64 KiB, the translated low word equals the routing word OR the offset of the request within the window.
- R12: Writes to offsets other than 0x900 to 0x91C change no state, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| req_valid | input | 1 | Local request present |
| req_addr | input | 64 | Local request address |
| out_valid | output | 1 | Translated request present (one cycle after `req_valid`) |
| out_hit | output | 1 | Request matched an enabled window |
| out_kind | output | 5 | Transaction kind of the matching window, 0 on a miss |
| out_addr | output | 64 | Translated address, or the request address on a miss |

## Verification
Requests are placed on each window's first and last byte and on the bytes just outside both ends, which tells an inclusive bound apart from an exclusive one. A request with the right low word but the wrong high word shows that the high word is compared. An address inside both windows exposes the priority order. A target near 2^64 exposes carry handling in the rewrite, and a configuration window with a bus, device and function word shows that the routing bits pass through. Register accesses check the selector's effect on which window is reached, the inbound lockout, out-of-order programming and a write on the same edge as a request. A long stretch of mixed valid and idle requests around the window edges is then compared on every clock against a behavioural model.

// File: rtl/atu_pkg.sv
package atu_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 2 * REG_W;
    localparam int KIND_W = 5;
    localparam int OFS_W  = 12;

    // register byte offsets
    localparam logic [OFS_W-1:0] OFS_VIEWPORT = 12'h900;
    localparam logic [OFS_W-1:0] OFS_KIND     = 12'h904;
    localparam logic [OFS_W-1:0] OFS_ENABLE   = 12'h908;
    localparam logic [OFS_W-1:0] OFS_BASE_LO  = 12'h90C;
    localparam logic [OFS_W-1:0] OFS_BASE_HI  = 12'h910;
    localparam logic [OFS_W-1:0] OFS_BOUND    = 12'h914;
    localparam logic [OFS_W-1:0] OFS_TGT_LO   = 12'h918;
    localparam logic [OFS_W-1:0] OFS_TGT_HI   = 12'h91C;

    localparam int VP_DIR_BIT = 31;
    localparam int EN_BIT     = 31;

    typedef enum logic [KIND_W-1:0] {
        KIND_MEM  = 5'd0,
        KIND_IO   = 5'd2,
        KIND_CFG0 = 5'd4,
        KIND_CFG1 = 5'd5
    } xlate_kind_e;

    typedef struct packed {
        logic              en;
        logic [KIND_W-1:0] kind;
        logic [REG_W-1:0]  base_lo;
        logic [REG_W-1:0]  base_hi;
        logic [REG_W-1:0]  bound;
        logic [REG_W-1:0]  tgt_lo;
        logic [REG_W-1:0]  tgt_hi;
    } window_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] addr;
    } xlate_res_t;

    function automatic logic in_window(window_t w, logic [ADDR_W-1:0] a);
        return w.en
            && (a[ADDR_W-1:REG_W] == w.base_hi)
            && (a[REG_W-1:0] >= w.base_lo)
            && (a[REG_W-1:0] <= w.bound);
    endfunction

    function automatic logic [ADDR_W-1:0] rewrite(window_t w, logic [ADDR_W-1:0] a);
        return {w.tgt_hi, w.tgt_lo} + (a - {w.base_hi, w.base_lo});
    endfunction

endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int IDX_W       = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic [OFS_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]             reg_wdata,
    output logic [REG_W-1:0]             reg_rdata,
    output window_t [NUM_REGIONS-1:0]    regs_q,
    output logic                         vp_inbound,
    output logic [IDX_W-1:0]             vp_idx
);

    localparam logic [IDX_W:0] REGION_CNT = (IDX_W+1)'(NUM_REGIONS);

    logic    win_ok;
    window_t sel;

    assign win_ok = !vp_inbound && ({1'b0, vp_idx} < REGION_CNT);
    assign sel    = win_ok ? regs_q[vp_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            vp_inbound <= 1'b0;
            vp_idx     <= '0;
            regs_q     <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_VIEWPORT) begin
                vp_inbound <= reg_wdata[VP_DIR_BIT];
                vp_idx     <= reg_wdata[IDX_W-1:0];
            end else if (win_ok) begin
                case (reg_addr)
                    OFS_KIND:    regs_q[vp_idx].kind    <= reg_wdata[KIND_W-1:0];
                    OFS_ENABLE:  regs_q[vp_idx].en      <= reg_wdata[EN_BIT];
                    OFS_BASE_LO: regs_q[vp_idx].base_lo <= reg_wdata;
                    OFS_BASE_HI: regs_q[vp_idx].base_hi <= reg_wdata;
                    OFS_BOUND:   regs_q[vp_idx].bound   <= reg_wdata;
                    OFS_TGT_LO:  regs_q[vp_idx].tgt_lo  <= reg_wdata;
                    OFS_TGT_HI:  regs_q[vp_idx].tgt_hi  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_VIEWPORT: reg_rdata = {vp_inbound, {(REG_W-1-IDX_W){1'b0}}, vp_idx};
            OFS_KIND:     reg_rdata = {{(REG_W-KIND_W){1'b0}}, sel.kind};
            OFS_ENABLE:   reg_rdata = {sel.en, {(REG_W-1){1'b0}}};
            OFS_BASE_LO:  reg_rdata = sel.base_lo;
            OFS_BASE_HI:  reg_rdata = sel.base_hi;
            OFS_BOUND:    reg_rdata = sel.bound;
            OFS_TGT_LO:   reg_rdata = sel.tgt_lo;
            OFS_TGT_HI:   reg_rdata = sel.tgt_hi;
            default:      reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/atu_match.sv
module atu_match
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 2
) (
    input  window_t [NUM_REGIONS-1:0]                 regs_q,
    input  logic    [ADDR_W-1:0]                      req_addr,
    output logic    [NUM_REGIONS-1:0]                 hit_vec,
    output logic    [NUM_REGIONS-1:0][ADDR_W-1:0]     xaddr,
    output logic    [NUM_REGIONS-1:0][KIND_W-1:0]     xkind
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        assign hit_vec[g] = in_window(regs_q[g], req_addr);
        assign xaddr[g]   = rewrite(regs_q[g], req_addr);
        assign xkind[g]   = regs_q[g].kind;
    end

endmodule

// File: rtl/atu_pick.sv
module atu_pick
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic [NUM_REGIONS-1:0]                hit_vec,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]    xaddr,
    input  logic [NUM_REGIONS-1:0][KIND_W-1:0]    xkind,
    output xlate_res_t                            res_q
);

    xlate_res_t res_d;

    // walk from the top index down so the lowest index is applied last
    always_comb begin
        res_d.valid = req_valid;
        res_d.hit   = 1'b0;
        res_d.kind  = KIND_MEM;
        res_d.addr  = req_addr;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                res_d.hit  = req_valid;
                res_d.kind = xkind[i];
                res_d.addr = xaddr[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

endmodule

// File: rtl/atu_outbound.sv
module atu_outbound
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [KIND_W-1:0] out_kind,
    output logic [ADDR_W-1:0] out_addr
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    window_t [NUM_REGIONS-1:0]              regs_q;
    logic                                   vp_inbound;
    logic [IDX_W-1:0]                       vp_idx;
    logic [NUM_REGIONS-1:0]                 hit_vec;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]     xaddr;
    logic [NUM_REGIONS-1:0][KIND_W-1:0]     xkind;
    xlate_res_t                             res_q;

    atu_regfile #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_regfile (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .regs_q     (regs_q),
        .vp_inbound (vp_inbound),
        .vp_idx     (vp_idx)
    );

    atu_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .regs_q   (regs_q),
        .req_addr (req_addr),
        .hit_vec  (hit_vec),
        .xaddr    (xaddr),
        .xkind    (xkind)
    );

    atu_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .hit_vec   (hit_vec),
        .xaddr     (xaddr),
        .xkind     (xkind),
        .res_q     (res_q)
    );

    assign out_valid = res_q.valid;
    assign out_hit   = res_q.hit;
    assign out_kind  = res_q.kind;
    assign out_addr  = res_q.addr;

endmodule

// File: rtl/atu_outbound_chk.sv
module atu_outbound_chk
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          reg_wr,
    input logic [OFS_W-1:0]              reg_addr,
    input logic                          vp_inbound,
    input window_t [NUM_REGIONS-1:0]     regs_q,
    input logic                          req_valid,
    input logic [ADDR_W-1:0]             req_addr,
    input logic [NUM_REGIONS-1:0]        hit_vec,
    input logic                          out_valid,
    input logic                          out_hit,
    input logic [ADDR_W-1:0]             out_addr
);

    // R10
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R10
    idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    // R10
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> out_valid);

    // R6
    window_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (hit_vec != '0)) |=> out_hit);

    // R9
    miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (hit_vec == '0)) |=> (!out_hit && (out_addr == $past(req_addr))));

    // R4
    inbound_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && vp_inbound && (reg_addr != OFS_VIEWPORT)) |=> $stable(regs_q));

endmodule

bind atu_outbound atu_outbound_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .vp_inbound (vp_inbound),
    .regs_q     (regs_q),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .hit_vec    (hit_vec),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_addr   (out_addr)
);

// File: tb/atu_outbound_bench.sv
`timescale 1ns/1ps
module atu_outbound_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [4:0]  out_kind;
    logic [63:0] out_addr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic [31:0] m_blo [2];
    logic [31:0] m_bhi [2];
    logic [31:0] m_lim [2];
    logic [31:0] m_tlo [2];
    logic [31:0] m_thi [2];
    logic [4:0]  m_kind[2];
    bit          m_en  [2];
    bit          m_inb;
    int          m_idx;

    always #2 clk = ~clk;

    atu_outbound u_atu_outbound (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_hit(out_hit),
        .out_kind(out_kind), .out_addr(out_addr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 2; i++) begin
            m_blo[i] = 0; m_bhi[i] = 0; m_lim[i] = 0; m_tlo[i] = 0; m_thi[i] = 0;
            m_kind[i] = 0; m_en[i] = 0;
        end
        m_inb = 0; m_idx = 0;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h900) begin
            m_inb = d[31];
            m_idx = d[0] ? 1 : 0;
        end else if (!m_inb) begin
            case (a)
                12'h904: m_kind[m_idx] = d[4:0];
                12'h908: m_en[m_idx]   = d[31];
                12'h90C: m_blo[m_idx]  = d;
                12'h910: m_bhi[m_idx]  = d;
                12'h914: m_lim[m_idx]  = d;
                12'h918: m_tlo[m_idx]  = d;
                12'h91C: m_thi[m_idx]  = d;
                default: ;
            endcase
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h900) return {m_inb, 30'd0, m_idx[0]};
        if (m_inb) return 32'd0;
        case (a)
            12'h904: return {27'd0, m_kind[m_idx]};
            12'h908: return {m_en[m_idx], 31'd0};
            12'h90C: return m_blo[m_idx];
            12'h910: return m_bhi[m_idx];
            12'h914: return m_lim[m_idx];
            12'h918: return m_tlo[m_idx];
            12'h91C: return m_thi[m_idx];
            default: return 32'd0;
        endcase
    endfunction

    // one clock: drive at negedge, predict, clock, compare at next negedge
    task automatic step(input bit wr, input logic [11:0] wa, input logic [31:0] wd,
                        input bit rv, input logic [63:0] ra, input string tag);
        bit          e_hit;
        logic [4:0]  e_kind;
        logic [63:0] e_addr;
        reg_wr = wr; reg_addr = wa; reg_wdata = wd;
        req_valid = rv; req_addr = ra;
        e_hit = 0; e_kind = 0; e_addr = ra;
        for (int i = 0; i < 2; i++) begin
            if (!e_hit && m_en[i] && ra[63:32] == m_bhi[i]
                && ra[31:0] >= m_blo[i] && ra[31:0] <= m_lim[i]) begin
                e_hit  = 1;
                e_kind = m_kind[i];
                e_addr = {m_thi[i], m_tlo[i]} + (ra - {m_bhi[i], m_blo[i]});
            end
        end
        if (wr) model_write(wa, wd);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0;
        chk({tag, " valid"}, 64'(out_valid), 64'(rv));
        chk({tag, " hit"}, 64'(out_hit), 64'(rv && e_hit));
        if (rv) begin
            chk({tag, " kind"}, 64'(out_kind), 64'(e_kind));
            chk({tag, " addr"}, out_addr, e_addr);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1, a, d, 0, 64'd0, tag);
    endtask

    task automatic rq(input logic [63:0] a, input string tag);
        step(0, 12'd0, 32'd0, 1, a, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        reg_wr = 0; reg_addr = a; req_valid = 0;
        #1;
        chk(tag, 64'(reg_rdata), 64'(model_read(a)));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 out_hit", 64'(out_hit), 64'd0);
        for (int a = 12'h900; a <= 12'h91C; a += 4) rd(12'(a), "R1 reset read");
        rq(64'h0000_0000_0000_0000, "R1 nothing enabled");

        // R2 selector
        wr(12'h900, 32'h0000_0001, "R2 select 1");
        rd(12'h900, "R2 readback 1");
        wr(12'h900, 32'hFFFF_FFFE, "R2 mask");
        rd(12'h900, "R2 readback mask");
        chk("R2 mask const", 64'(reg_rdata), 64'h8000_0000);

        // R4 inbound lockout
        wr(12'h90C, 32'h1234_5678, "R4 inbound write");
        rd(12'h90C, "R4 inbound read");
        chk("R4 inbound read zero", 64'(reg_rdata), 64'd0);
        wr(12'h900, 32'h0000_0000, "R4 back outbound");
        rd(12'h90C, "R4 region0 untouched");
        chk("R4 region0 const", 64'(reg_rdata), 64'd0);

        // R3 program region 0, enable first (any order)
        wr(12'h908, 32'h8000_0000, "R3 r0 en");
        wr(12'h91C, 32'h0000_0004, "R3 r0 thi");
        wr(12'h904, 32'h0000_0000, "R3 r0 kind");
        wr(12'h914, 32'h1000_FFFF, "R3 r0 bound");
        wr(12'h90C, 32'h1000_0000, "R3 r0 blo");
        wr(12'h910, 32'h0000_0001, "R3 r0 bhi");
        wr(12'h918, 32'h0000_0000, "R3 r0 tlo");
        // region 1, enable last, bit30 set too
        wr(12'h900, 32'h0000_0001, "R3 sel1");
        wr(12'h904, 32'h0000_0002, "R3 r1 kind");
        wr(12'h90C, 32'h1000_8000, "R3 r1 blo");
        wr(12'h910, 32'h0000_0001, "R3 r1 bhi");
        wr(12'h914, 32'h1002_0000, "R3 r1 bound");
        wr(12'h918, 32'h8000_0000, "R3 r1 tlo");
        wr(12'h91C, 32'h0000_0000, "R3 r1 thi");
        wr(12'h908, 32'hC000_0001, "R5 r1 en with bit30");
        for (int a = 12'h904; a <= 12'h91C; a += 4) rd(12'(a), "R3 r1 readback");
        rd(12'h908, "R5 enable read");
        chk("R5 enable const", 64'(reg_rdata), 64'h8000_0000);
        rd(12'h90C, "R3 r1 blo");
        chk("R3 r1 blo const", 64'(reg_rdata), 64'h1000_8000);
        wr(12'h900, 32'h0000_0000, "R3 sel0");
        for (int a = 12'h904; a <= 12'h91C; a += 4) rd(12'(a), "R3 r0 readback");
        rd(12'h914, "R3 r0 bound");
        chk("R3 r0 bound const", 64'(reg_rdata), 64'h1000_FFFF);

        // R6 / R7 / R8 / R9 translation edges
        rq(64'h0000_0001_1000_0000, "R6 r0 base");
        chk("R7 r0 base const", out_addr, 64'h0000_0004_0000_0000);
        rq(64'h0000_0001_1000_FFFF, "R8 overlap at r0 bound");
        chk("R8 r0 wins kind", 64'(out_kind), 64'd0);
        chk("R8 r0 wins addr", out_addr, 64'h0000_0004_0000_FFFF);
        rq(64'h0000_0001_1001_0000, "R7 r1 only");
        chk("R7 r1 const", out_addr, 64'h0000_0000_8000_8000);
        chk("R7 r1 kind", 64'(out_kind), 64'd2);
        rq(64'h0000_0001_1002_0000, "R6 r1 bound");
        rq(64'h0000_0001_1002_0001, "R9 above bound");
        chk("R9 passthrough", out_addr, 64'h0000_0001_1002_0001);
        rq(64'h0000_0001_0FFF_FFFF, "R6 below base");
        rq(64'h0000_0002_1000_0010, "R6 high word mismatch");
        chk("R6 high word miss", 64'(out_hit), 64'd0);

        // R10 write on the same edge as a request
        step(1, 12'h908, 32'h0000_0000, 1, 64'h0000_0001_1000_0010, "R10 same-edge");
        chk("R10 old window used", out_addr, 64'h0000_0004_0000_0010);
        rq(64'h0000_0001_1000_0010, "R6 disabled r0");
        chk("R6 disabled miss", 64'(out_hit), 64'd0);

        // R7 wraparound on region 1
        wr(12'h900, 32'h0000_0001, "R7 sel1");
        wr(12'h91C, 32'hFFFF_FFFF, "R7 thi");
        wr(12'h918, 32'hFFFF_F000, "R7 tlo");
        rq(64'h0000_0001_1000_9800, "R7 wrap");
        chk("R7 wrap const", out_addr, 64'h0000_0000_0000_0800);

        // R11 configuration routing on region 0
        wr(12'h900, 32'h0000_0000, "R11 sel0");
        wr(12'h904, 32'h0000_0004, "R11 kind cfg0");
        wr(12'h910, 32'h0000_0000, "R11 bhi");
        wr(12'h90C, 32'h2000_0000, "R11 blo");
        wr(12'h914, 32'h2000_0FFF, "R11 bound");
        wr(12'h918, (32'd3 << 24) | (32'd5 << 19) | (32'd2 << 16), "R11 routing word");
        wr(12'h91C, 32'h0000_0000, "R11 thi");
        wr(12'h908, 32'h8000_0000, "R11 en");
        rq(64'h0000_0000_2000_0044, "R11 cfg access");
        chk("R11 routed const", out_addr, 64'h0000_0000_032A_0044);
        chk("R11 kind", 64'(out_kind), 64'd4);

        // R12 unmapped offsets
        wr(12'h920, 32'hFFFF_FFFF, "R12 write 920");
        wr(12'h000, 32'hFFFF_FFFF, "R12 write 000");
        rd(12'h920, "R12 read 920");
        chk("R12 read zero", 64'(reg_rdata), 64'd0);
        for (int a = 12'h900; a <= 12'h91C; a += 4) rd(12'(a), "R12 state unchanged");
        rq(64'h0000_0000_2000_0044, "R12 translation unchanged");

        // mixed stream around window edges, compared every clock
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a;
            bit          v;
            v = ($urandom % 4) != 0;
            case ($urandom % 3)
                0: a = {32'h1, 32'h1000_0000 + 32'($urandom % 32'h3_0000) - 32'h100};
                1: a = {32'h0, 32'h2000_0000 + 32'($urandom % 32'h2000) - 32'h10};
                default: a = {32'($urandom % 3), 32'h1000_8000 + 32'($urandom % 32'h100)};
            endcase
            if (n == 200) begin
                wr(12'h900, 32'h0000_0001, "R8 stream sel1");
                wr(12'h91C, 32'h0000_0000, "R8 stream thi");
            end
            step(0, 12'd0, 32'd0, v, a, "R7 stream");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule